// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

The sequencer turns one word-sized read or write request from a host-side port into a timed cycle on a simple strobed local bus. That bus has a word address, separate write-data and read-data buses, and three active-low strobes: a select, a read strobe and a write strobe. The host hands over a byte offset, a direction flag and write data in a single-clock request pulse. The block then runs a fixed sequence: it drives the address for a setup clock, holds the select and one direction strobe low for two clocks, samples read data halfway through, releases the strobes, and acknowledges the host for one clock.

The block runs from a bus clock of roughly 33 MHz, so one clock is about 30 ns. The lengths of the setup, strobe and sample phases are parameters. The offset window above the usable range is reserved. A request that targets it is refused without touching the local bus. Only one cycle can be in progress at a time.

Top module: `lbus_sequencer`

## Requirements
- R1: After reset, `lb_cs_n`, `lb_rd_n` and `lb_wr_n` are 1, `lb_addr` and `lb_wdata` are 0, `host_ack` is 0, and the sequencer is idle.
- R2: `lb_addr` takes bits 14..2 of `host_offset` (bits 1..0 are dropped) on the clock edge that accepts the request. It holds that value while the strobes are low and until the next accepted request. `lb_cs_n` stays high for one setup clock after the address appears.
- R3: `lb_cs_n` falls together with `lb_rd_n` for a read (`host_write`=0) or with `lb_wr_n` for a write (`host_write`=1). It stays low for exactly two clocks, and both signals return high on the same edge. The other direction strobe stays high for the whole cycle.
- R4: On a read, `lb_rdata` is sampled on the edge one clock after the strobes fall. That value is presented on `host_rdata` while `host_ack` is 1. A write acknowledges with `host_rdata` = 0.
- R5: On a write, `lb_wdata` carries `host_wdata` from the accepting edge and stays constant while `lb_wr_n` is low. A read leaves `lb_wdata` unchanged.
- R6: `host_ack` is 1 for exactly one clock. For a normal cycle it rises on the edge where the strobes return high, with `host_err` = 0.
- R7: A request with `host_offset` >= 0x8000 (bit 15 set) produces no local bus activity: the strobes stay high and `lb_addr` is unchanged. On the next edge it is answered with `host_ack` = 1, `host_err` = 1 and `host_rdata` = 0.
- R8: A request is taken only when the sequencer is idle. A `host_req` pulse while a cycle is in progress is ignored and starts no later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | One-clock request pulse |
| host_write | input | 1 | 1 = write, 0 = read |
| host_offset | input | 16 | Byte offset of the access |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-clock completion pulse |
| host_err | output | 1 | Reserved-offset refusal, valid with `host_ack` |
| host_rdata | output | 32 | Read data, valid with `host_ack` |
| lb_addr | output | 13 | Local bus word address |
| lb_wdata | output | 32 | Local bus write data |
| lb_rdata | input | 32 | Local bus read data |
| lb_cs_n | output | 1 | Select, active low |
| lb_rd_n | output | 1 | Read strobe, active low |
| lb_wr_n | output | 1 | Write strobe, active low |

## Verification
Take the edge that accepts a request as edge 0. The address and write data are due after edge 0 and the strobes fall after edge 1. Read data is taken at edge 2, and the strobes rise together with the acknowledge at edge 3. The acknowledge is gone after edge 4. A reserved-offset request is instead acknowledged right after edge 0. The bench drives inputs and samples outputs on falling edges, one falling edge after each of these rising edges. It changes `lb_rdata` to the expected word only once the strobes are low, and corrupts it after edge 2, so a sample taken on the wrong edge shows up in `host_rdata`.

// File: rtl/lbus_sequencer.sv
module lbus_sequencer #(
  parameter int OFS_W       = 16,
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 32,
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 2,
  parameter int SAMPLE_CLK  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_write,
  input  logic [OFS_W-1:0]  host_offset,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic              host_err,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] lb_addr,
  output logic [DATA_W-1:0] lb_wdata,
  input  logic [DATA_W-1:0] lb_rdata,
  output logic              lb_cs_n,
  output logic              lb_rd_n,
  output logic              lb_wr_n
);

  localparam int WIN_BIT = ADDR_W + 2;
  localparam int CNT_W   = $clog2(SETUP_CLKS + STROBE_CLKS + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CLKS - 1);
  localparam logic [CNT_W-1:0] SAMPLE_CNT  = CNT_W'(STROBE_CLKS - SAMPLE_CLK);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_DONE} state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr;
  logic              reserved;

  assign reserved = |host_offset[OFS_W-1:WIN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      is_wr      <= 1'b0;
      lb_addr    <= '0;
      lb_wdata   <= '0;
      host_rdata <= '0;
      host_ack   <= 1'b0;
      host_err   <= 1'b0;
    end else begin
      host_ack <= 1'b0;
      case (st)
        S_IDLE: if (host_req) begin
          host_rdata <= '0;
          if (reserved) begin
            host_ack <= 1'b1;
            host_err <= 1'b1;
            st       <= S_DONE;
          end else begin
            host_err <= 1'b0;
            lb_addr  <= host_offset[WIN_BIT-1:2];
            is_wr    <= host_write;
            if (host_write) lb_wdata <= host_wdata;
            cnt      <= SETUP_LAST;
            st       <= S_SETUP;
          end
        end
        S_SETUP:
          if (cnt == '0) begin
            cnt <= STROBE_LAST;
            st  <= S_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_STROBE: begin
          if (!is_wr && cnt == SAMPLE_CNT) host_rdata <= lb_rdata;
          if (cnt == '0) begin
            host_ack <= 1'b1;
            st       <= S_DONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lb_cs_n = (st != S_STROBE);
  assign lb_rd_n = lb_cs_n | is_wr;
  assign lb_wr_n = lb_cs_n | ~is_wr;

  p_strobe_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lb_cs_n == ($countones({~lb_rd_n, ~lb_wr_n}) == 0)) else $error("strobe pairing");
  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~lb_rd_n, ~lb_wr_n})) else $error("both direction strobes low");
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_cs_n |-> $stable(lb_addr)) else $error("address moved under strobe");
  p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_wr_n |-> $stable(lb_wdata)) else $error("write data moved under strobe");
  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack) else $error("ack longer than one clock");
  p_ack_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !host_err) |-> $rose(lb_cs_n)) else $error("ack not at strobe release");
  p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && host_err) |-> (lb_cs_n && host_rdata == '0 && $stable(lb_addr)))
    else $error("reserved request touched the bus");

endmodule

// File: tb/lbus_sequencer_test.sv
module lbus_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_write = 1'b0;
  logic [15:0] host_offset = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ack, host_err;
  logic [31:0] host_rdata;
  logic [12:0] lb_addr;
  logic [31:0] lb_wdata;
  logic [31:0] lb_rdata = '0;
  logic        lb_cs_n, lb_rd_n, lb_wr_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  lbus_sequencer uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
    .host_offset(host_offset), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_err(host_err), .host_rdata(host_rdata), .lb_addr(lb_addr),
    .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_cs_n(lb_cs_n),
    .lb_rd_n(lb_rd_n), .lb_wr_n(lb_wr_n)
  );

  always #5 clk = ~clk;

  localparam int NV = 6;
  localparam logic        V_WR  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [15:0] V_OFS [NV] = '{16'h000C, 16'h000C, 16'h7FFC, 16'h7FFC, 16'h0006, 16'h0000};
  localparam logic [31:0] V_DAT [NV] = '{32'h0000_7777, 32'hA5A5_0F0F, 32'hDEAD_BEEF,
                                         32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0001};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic wr, input logic [15:0] ofs, input logic [31:0] dat);
    logic [31:0] wd_prev;
    wd_prev = lb_wdata;
    host_req = 1'b1; host_write = wr; host_offset = ofs; host_wdata = dat;
    @(posedge clk); @(negedge clk);
    host_req = 1'b0; host_wdata = ~dat;
    chk("R2 addr after accept", 32'(lb_addr), 32'(ofs[14:2]));
    chk("R2 setup clock cs high", 32'(lb_cs_n), 32'd1);
    chk("R5 wdata", lb_wdata, wr ? dat : wd_prev);
    @(posedge clk); @(negedge clk);
    chk("R3 cs low", 32'(lb_cs_n), 32'd0);
    chk("R3 rd strobe", 32'(lb_rd_n), 32'(wr));
    chk("R3 wr strobe", 32'(lb_wr_n), 32'(!wr));
    lb_rdata = dat;
    @(posedge clk); @(negedge clk);
    chk("R3 cs low 2nd clock", 32'(lb_cs_n), 32'd0);
    chk("R2 addr held", 32'(lb_addr), 32'(ofs[14:2]));
    chk("R5 wdata held", lb_wdata, wr ? dat : wd_prev);
    lb_rdata = ~dat;
    @(posedge clk); @(negedge clk);
    chk("R3 strobes released", 32'({lb_cs_n, lb_rd_n, lb_wr_n}), 32'h7);
    chk("R6 ack", 32'(host_ack), 32'd1);
    chk("R6 no err", 32'(host_err), 32'd0);
    chk("R4 rdata", host_rdata, wr ? 32'h0 : dat);
    @(posedge clk); @(negedge clk);
    chk("R6 ack one clock", 32'(host_ack), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobes", 32'({lb_cs_n, lb_rd_n, lb_wr_n}), 32'h7);
    chk("R1 addr", 32'(lb_addr), 32'h0);
    chk("R1 wdata", lb_wdata, 32'h0);
    chk("R1 ack", 32'(host_ack), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) bus_cycle(V_WR[i], V_OFS[i], V_DAT[i]);

    // R7: reserved offsets
    host_req = 1'b1; host_write = 1'b1; host_offset = 16'h8000; host_wdata = 32'hCAFE_F00D;
    @(posedge clk); @(negedge clk);
    host_req = 1'b0;
    chk("R7 ack", 32'(host_ack), 32'd1);
    chk("R7 err", 32'(host_err), 32'd1);
    chk("R7 rdata zero", host_rdata, 32'h0);
    chk("R7 strobes high", 32'({lb_cs_n, lb_rd_n, lb_wr_n}), 32'h7);
    chk("R7 addr unchanged", 32'(lb_addr), 32'h0);
    chk("R7 wdata unchanged", lb_wdata, 32'h0000_0001);
    @(posedge clk); @(negedge clk);
    chk("R7 ack one clock", 32'(host_ack), 32'd0);
    host_req = 1'b1; host_write = 1'b0; host_offset = 16'hFFFC;
    @(posedge clk); @(negedge clk);
    host_req = 1'b0;
    chk("R7 top offset err", 32'(host_err & host_ack), 32'd1);
    repeat (3) begin
      @(negedge clk);
      chk("R7 top offset no cycle", 32'(lb_cs_n), 32'd1);
    end

    // R8: request while busy is dropped
    host_req = 1'b1; host_write = 1'b0; host_offset = 16'h0040;
    @(posedge clk); @(negedge clk);
    host_offset = 16'h0100; host_write = 1'b1; host_wdata = 32'h5555_AAAA;
    @(posedge clk); @(negedge clk);
    host_req = 1'b0;
    chk("R8 addr kept", 32'(lb_addr), 32'h10);
    lb_rdata = 32'h0BAD_CAFE;
    @(posedge clk); @(negedge clk);
    lb_rdata = 32'h0;
    @(posedge clk); @(negedge clk);
    chk("R8 first cycle done", 32'(host_ack), 32'd1);
    chk("R4 busy read data", host_rdata, 32'h0BAD_CAFE);
    repeat (4) begin
      @(negedge clk);
      chk("R8 no second cycle", 32'({lb_cs_n, lb_addr}), {18'h0, 1'b1, 13'h10});
    end
    chk("R8 wdata untouched", lb_wdata, 32'h0000_0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule